// File: doc/BRIEF.md
# Multi-Rate Row Refresh Scheduler

This block issues row refresh commands to a memory array. Each row gets one of two refresh rates. A one-bit rate table holds the rate for every row. A row whose bit is 1 is weak and is refreshed in every base period. A row whose bit is 0 is strong and is refreshed only in every fourth base period. Most rows tolerate the longer interval, so this cuts the number of refresh commands a great deal compared with a single global rate.

A base period is divided into one slot per row. A scaled time tick marks each slot, which lets simulation use short periods. Before normal operation, a profiling port loads the rate table one row at a time. While the array is in use, upgrade requests can raise any row to the fast rate at any time. A raised bit stays set until the profiling port writes it again. Commands leave through a row/valid/ready port. A command that the port stalls is held until it is accepted and is never lost. A counter shows how many slots were skipped because their row was strong.

Top module: `mrr_sched`

## Requirements
- R1: After reset, `ref_valid` is 0, `skip_cnt` is 0, the next slot is row 0 in round 0, and every rate bit is 0 (slow).
- R2: When `prof_we` is 1 on a clock edge, the rate bit of row `prof_row` takes the value of `prof_rate`.
- R3: Each `tick` seen while `run` is 1 evaluates one slot. Slots take rows in increasing order from 0 to ROWS-1 and then wrap to 0. The round count (modulo 4) increases on each wrap. A command that is due appears on `ref_valid`/`ref_row` one cycle after the tick edge.
- R4: A row whose rate bit is 1 receives one refresh command in every round.
- R5: A row whose rate bit is 0 receives a refresh command only in rounds where the round count modulo 4 is 0.
- R6: Each evaluated slot that issues no command adds 1 to `skip_cnt`. The count saturates at its maximum value.
- R7: `upg_valid` sets the rate bit of row `upg_row` to 1. If a profile write targets the same row in the same cycle, the upgrade wins and the bit ends up 1.
- R8: While `ref_valid` is 1 and `ref_ready` is 0, `ref_valid` stays 1 and `ref_row` does not change.
- R9: A tick that arrives while a command is pending is deferred, not dropped. At most one tick is deferred. The deferred slot is evaluated on the edge where the pending command is accepted, so a due command can follow the accepted one with no idle cycle.
- R10: While `run` is 0, ticks are ignored. No command is issued and the slot position does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Enables slot evaluation |
| tick | input | 1 | One pulse per refresh slot |
| prof_we | input | 1 | Profile write strobe |
| prof_row | input | ROW_W | Row written by the profile port |
| prof_rate | input | 1 | Rate bit value (1 = fast, 0 = slow) |
| upg_valid | input | 1 | Upgrade request strobe |
| upg_row | input | ROW_W | Row forced to the fast rate |
| ref_valid | output | 1 | Refresh command pending |
| ref_row | output | ROW_W | Row to refresh |
| ref_ready | input | 1 | Command accepted when high with ref_valid |
| skip_cnt | output | CNT_W | Saturating count of skipped slow slots |

## Verification
The bench loads a mixed rate pattern and sweeps eight full rounds. Every slot is compared against an arithmetic model, which separates the rounds where slow rows are due from the rounds where they are skipped. A same-row collision between a profile write and an upgrade shows which of the two has priority. An upgrade made in the middle of the sweep shows that the raised bit takes effect in a later non-zero round. A stalled port with an extra tick exercises the hold and deferral path. Ticks sent with `run` low must leave both the command port and the slot position unchanged.

// File: rtl/mrr_sched.sv
module mrr_sched #(
  parameter int ROWS     = 16,
  parameter int SLOW_DIV = 4,
  parameter int CNT_W    = 16,
  parameter int ROW_W    = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             prof_we,
  input  logic [ROW_W-1:0] prof_row,
  input  logic             prof_rate,
  input  logic             upg_valid,
  input  logic [ROW_W-1:0] upg_row,
  output logic             ref_valid,
  output logic [ROW_W-1:0] ref_row,
  input  logic             ref_ready,
  output logic [CNT_W-1:0] skip_cnt
);
  localparam int RND_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);
  localparam logic [RND_W-1:0] LAST_RND = RND_W'(SLOW_DIV - 1);

  logic [ROWS-1:0]  rate_q;
  logic [ROW_W-1:0] slot_q;
  logic [RND_W-1:0] round_q;
  logic             pend_q, owed_q;

  wire accept = pend_q & ref_ready;
  wire fire   = run & (tick | owed_q) & (~pend_q | accept);
  wire due    = rate_q[slot_q] | (round_q == '0);
  wire wrap   = (slot_q == LAST_ROW);

  assign ref_valid = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q   <= '0;
      round_q  <= '0;
      pend_q   <= 1'b0;
      owed_q   <= 1'b0;
      ref_row  <= '0;
      skip_cnt <= '0;
    end else begin
      if (fire) begin
        owed_q  <= tick & owed_q;
        pend_q  <= due;
        slot_q  <= wrap ? '0 : slot_q + 1'b1;
        if (wrap) round_q <= (round_q == LAST_RND) ? '0 : round_q + 1'b1;
        if (due) ref_row <= slot_q;
        else if (skip_cnt != '1) skip_cnt <= skip_cnt + 1'b1;
      end else begin
        owed_q <= owed_q | (run & tick);
        pend_q <= pend_q & ~ref_ready;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ROWS; i++) begin
      if (!rst_n) rate_q[i] <= 1'b0;
      else if (upg_valid && upg_row == ROW_W'(i)) rate_q[i] <= 1'b1;
      else if (prof_we && prof_row == ROW_W'(i)) rate_q[i] <= prof_rate;
    end
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid && !ref_ready |=> ref_valid && $stable(ref_row));
  p_upgrade_sticks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    upg_valid |=> rate_q[$past(upg_row)]);
  p_skip_mono_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> skip_cnt >= $past(skip_cnt));
  p_row_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid |-> int'(ref_row) < ROWS);
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(slot_q));
endmodule

// File: tb/tb_mrr_sched.sv
module tb_mrr_sched;
  localparam int ROWS = 8;
  localparam int RW = 3;
  localparam int CW = 16;

  logic clk = 0, rst_n = 0, run = 0, tick = 0;
  logic prof_we = 0, prof_rate = 0, upg_valid = 0, ref_ready = 1;
  logic [RW-1:0] prof_row = '0, upg_row = '0;
  logic ref_valid;
  logic [RW-1:0] ref_row;
  logic [CW-1:0] skip_cnt;

  mrr_sched #(.ROWS(ROWS), .SLOW_DIV(4), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
    .prof_we(prof_we), .prof_row(prof_row), .prof_rate(prof_rate),
    .upg_valid(upg_valid), .upg_row(upg_row),
    .ref_valid(ref_valid), .ref_row(ref_row), .ref_ready(ref_ready),
    .skip_cnt(skip_cnt));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit [ROWS-1:0] m_rate = 8'b1000_1001;
  int m_slot = 0, m_round = 0, m_skip = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic advance();
    m_slot++;
    if (m_slot == ROWS) begin m_slot = 0; m_round++; end
  endtask

  task automatic slot_step();
    bit due;
    @(negedge clk) tick = 1;
    @(negedge clk) tick = 0;
    due = m_rate[m_slot] || (m_round % 4 == 0);
    if (due) begin
      chk(ref_valid == 1, m_rate[m_slot] ? "R4 fast row issued" : "R5 slow row issued in round 0 mod 4", ref_valid, 1);
      chk(ref_row == RW'(m_slot), "R3 slot order", ref_row, m_slot);
      @(negedge clk);
      chk(ref_valid == 0, "R3 accepted", ref_valid, 0);
    end else begin
      chk(ref_valid == 0, "R5 slow row skipped", ref_valid, 0);
      m_skip++;
    end
    advance();
  endtask

  initial begin
    #(5.0 * 200000);
    chk(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ref_valid == 0, "R1 reset valid", ref_valid, 0);
    chk(skip_cnt == 0, "R1 reset skip", skip_cnt, 0);
    rst_n = 1;
    // R2: load profile
    for (int i = 0; i < ROWS; i++) begin
      @(negedge clk) prof_we = 1; prof_row = RW'(i); prof_rate = m_rate[i];
    end
    // R7 collision: profile clears row 5, upgrade sets it
    @(negedge clk) prof_row = 3'd5; prof_rate = 0; upg_valid = 1; upg_row = 3'd5;
    m_rate[5] = 1;
    @(negedge clk) prof_we = 0; upg_valid = 0;
    run = 1;
    for (int s = 0; s < 8 * ROWS; s++) begin
      if (s == 5 * ROWS) begin
        @(negedge clk) upg_valid = 1; upg_row = 3'd2;
        @(negedge clk) upg_valid = 0;
        m_rate[2] = 1; // R7 runtime upgrade
      end
      slot_step();
    end
    chk(skip_cnt == CW'(m_skip), "R6 skip count", skip_cnt, m_skip);
    // R8/R9 stall at round 8 (mod 4 = 0), slot 0
    ref_ready = 0;
    @(negedge clk) tick = 1;
    @(negedge clk) tick = 0;
    chk(ref_valid == 1 && ref_row == 0, "R8 stalled cmd", ref_row, 0);
    repeat (3) begin
      @(negedge clk);
      chk(ref_valid == 1 && ref_row == 0, "R8 hold", ref_row, 0);
    end
    tick = 1;
    @(negedge clk) tick = 0;
    chk(ref_valid == 1 && ref_row == 0, "R9 held under extra tick", ref_row, 0);
    ref_ready = 1;
    @(negedge clk);
    chk(ref_valid == 1 && ref_row == 1, "R9 deferred slot follows", ref_row, 1);
    @(negedge clk);
    chk(ref_valid == 0, "R9 drained", ref_valid, 0);
    advance(); advance();
    // R10: run low
    run = 0;
    repeat (3) begin
      @(negedge clk) tick = 1;
      @(negedge clk) tick = 0;
      chk(ref_valid == 0, "R10 no cmd when idle", ref_valid, 0);
    end
    run = 1;
    for (int s = 0; s < ROWS; s++) slot_step();
    chk(skip_cnt == CW'(m_skip), "R6 final skip count", skip_cnt, m_skip);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule